// File: doc/BRIEF.md
# AC-link Serial Frame Controller

This block is the controller end of an AC'97-style serial audio link. The codec supplies the bit clock, and the block runs entirely in that clock domain. It counts the bits of each frame and drives the frame sync. It shifts out a 256-bit frame that holds a 16-bit tag and twelve 20-bit slots of control and DAC data. It shifts in the matching frames of control and ADC data from a primary codec and, when enabled, from a second codec.

Outgoing data is presented on parallel holding inputs, which are taken once per frame at the frame boundary. Incoming frames are gathered by shift registers clocked on the falling bit-clock edge. After the last bit of a frame, they are copied into parallel capture outputs, and a one-cycle strobe marks the copy. The block also reports codec readiness. This is the primary ready flag (tag bit 15), ORed with the second codec's ready flag when the second input is enabled.

Top module: `aclink_frame_ctrl`

## Requirements
- R1: A frame is 256 bit-clock periods long; `sync_out` is high for the first 16 periods of each frame and low for the remaining 240, repeating without gaps.
- R2: `sdata_out` sends the 256-bit word {tx_tag, tx_slots} MSB first, one bit per period, changing on the rising edge; bit 255 (tx_tag[15]) goes out in the same period that `sync_out` rises; slot 1 occupies tx_slots[239:220] and slot 12 tx_slots[19:0].
- R3: `tx_tag` and `tx_slots` are taken only on the rising edge that starts a frame; changing them later in the frame does not alter the bits sent in that frame.
- R4: `sdin_a` and `sdin_b` are sampled on the falling edge, one bit per period, aligned with the output bits. On the rising edge that starts the next frame, the primary frame appears on `rx_tag` (frame bits 255:240) and `rx_slots` (frame bits 239:0), in the same layout as R2. `frame_done` is high for exactly that one cycle.
- R5: At each capture, `codec_ready` becomes bit 15 of the primary tag ORed with bit 15 of the secondary tag when `sec_en` is high.
- R6: When `sec_en` is low at capture, the secondary input is ignored: `rx_tag_b` becomes zero and the secondary ready bit has no effect on `codec_ready`; when high, `rx_tag_b` holds the secondary tag.
- R7: While `rst` (synchronous, active high) is sampled high, `sdata_out`, `sync_out`, `frame_done`, `codec_ready`, `rx_tag`, `rx_slots` and `rx_tag_b` are zero and the bit counter is cleared. The first rising edge after release starts a new frame at bit 0, and no `frame_done` occurs until a complete frame has been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock from the codec |
| rst | input | 1 | Synchronous active-high link reset |
| sec_en | input | 1 | Enables the second serial input |
| tx_tag | input | 16 | Outgoing tag word, taken at frame start |
| tx_slots | input | 240 | Outgoing slots 1..12, slot 1 in the top bits |
| sdin_a | input | 1 | Serial data from the primary codec |
| sdin_b | input | 1 | Serial data from the second codec |
| sdata_out | output | 1 | Serial data to the codec |
| sync_out | output | 1 | Frame sync |
| rx_tag | output | 16 | Captured primary tag |
| rx_slots | output | 240 | Captured primary slots 1..12 |
| rx_tag_b | output | 16 | Captured secondary tag, zero when disabled |
| frame_done | output | 1 | One-cycle strobe when captures update |
| codec_ready | output | 1 | Merged codec ready status |

## Verification
The vector table sends frames whose tag and slot contents come from distinct seeds, so a slot swap, a bit-order reversal or an off-by-one shift shows up as a mismatch on a specific bit. The ready cases cover every combination that separates an OR merge from AND or primary-only logic: primary only, secondary only with the input enabled, secondary only with it disabled, neither, and both. The holding inputs are inverted mid-frame to show that the load happens only at the boundary. A reset in the middle of a frame checks that the outputs are forced low, that framing restarts, and that no capture strobe occurs early.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
    localparam int TAG_W     = 16;
    localparam int SLOT_W    = 20;
    localparam int NSLOTS    = 12;
    localparam int NLANES    = 2;
    localparam int PAY_W     = NSLOTS * SLOT_W;
    localparam int FRAME_W   = TAG_W + PAY_W;
    localparam int CNT_W     = $clog2(FRAME_W);
    localparam int READY_BIT = TAG_W - 1;

    typedef logic [CNT_W-1:0] bitcnt_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [PAY_W-1:0] slots;
    } frame_t;

    function automatic logic is_last(bitcnt_t c);
        return c == bitcnt_t'(FRAME_W - 1);
    endfunction

    function automatic logic in_tag(bitcnt_t c);
        return c < bitcnt_t'(TAG_W);
    endfunction
endpackage

// File: rtl/aclink_seq.sv
module aclink_seq import aclink_pkg::*; (
    input  logic clk,
    input  logic rst,
    output logic frame_start,
    output logic tag_phase,
    output logic full_seen
);
    bitcnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            full_seen <= 1'b0;
        end else begin
            cnt <= is_last(cnt) ? '0 : cnt + 1'b1;
            if (is_last(cnt))
                full_seen <= 1'b1;
        end
    end

    assign frame_start = (cnt == '0);
    assign tag_phase   = in_tag(cnt);
endmodule

// File: rtl/aclink_tx.sv
module aclink_tx import aclink_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               tag_phase,
    input  logic [FRAME_W-1:0] load_word,
    output logic               sdo,
    output logic               sync
);
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            sdo   <= 1'b0;
            sync  <= 1'b0;
        end else begin
            sync <= tag_phase;
            if (frame_start) begin
                sdo   <= load_word[FRAME_W-1];
                shreg <= {load_word[FRAME_W-2:0], 1'b0};
            end else begin
                sdo   <= shreg[FRAME_W-1];
                shreg <= {shreg[FRAME_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/aclink_rx_lane.sv
module aclink_rx_lane import aclink_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic               sdin,
    output logic [FRAME_W-1:0] word
);
    always_ff @(negedge clk) begin
        if (rst)
            word <= '0;
        else
            word <= {word[FRAME_W-2:0], sdin};
    end
endmodule

// File: rtl/aclink_frame_ctrl.sv
module aclink_frame_ctrl import aclink_pkg::*; (
    input  logic              bit_clk,
    input  logic              rst,
    input  logic              sec_en,
    input  logic [TAG_W-1:0]  tx_tag,
    input  logic [PAY_W-1:0]  tx_slots,
    input  logic              sdin_a,
    input  logic              sdin_b,
    output logic              sdata_out,
    output logic              sync_out,
    output logic [TAG_W-1:0]  rx_tag,
    output logic [PAY_W-1:0]  rx_slots,
    output logic [TAG_W-1:0]  rx_tag_b,
    output logic              frame_done,
    output logic              codec_ready
);
    logic               frame_start;
    logic               tag_phase;
    logic               full_seen;
    logic [NLANES-1:0]  sdin_v;
    logic [FRAME_W-1:0] lane_word [NLANES];
    frame_t             tx_frame;
    frame_t             rx_a;
    frame_t             rx_b;

    aclink_seq u_seq (
        .clk         (bit_clk),
        .rst         (rst),
        .frame_start (frame_start),
        .tag_phase   (tag_phase),
        .full_seen   (full_seen)
    );

    assign tx_frame.tag   = tx_tag;
    assign tx_frame.slots = tx_slots;

    aclink_tx u_tx (
        .clk         (bit_clk),
        .rst         (rst),
        .frame_start (frame_start),
        .tag_phase   (tag_phase),
        .load_word   (tx_frame),
        .sdo         (sdata_out),
        .sync        (sync_out)
    );

    assign sdin_v = {sdin_b, sdin_a};

    for (genvar ln = 0; ln < NLANES; ln++) begin : g_lane
        aclink_rx_lane u_lane (
            .clk  (bit_clk),
            .rst  (rst),
            .sdin (sdin_v[ln]),
            .word (lane_word[ln])
        );
    end

    assign rx_a = frame_t'(lane_word[0]);
    assign rx_b = frame_t'(lane_word[1]);

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            rx_tag      <= '0;
            rx_slots    <= '0;
            rx_tag_b    <= '0;
            frame_done  <= 1'b0;
            codec_ready <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (frame_start && full_seen) begin
                rx_tag      <= rx_a.tag;
                rx_slots    <= rx_a.slots;
                rx_tag_b    <= sec_en ? rx_b.tag : '0;
                codec_ready <= rx_a.tag[READY_BIT] | (sec_en & rx_b.tag[READY_BIT]);
                frame_done  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/aclink_frame_chk.sv
module aclink_frame_chk import aclink_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             sec_en,
    input logic             sync_out,
    input logic             sdata_out,
    input logic             frame_done,
    input logic             codec_ready,
    input logic [TAG_W-1:0] rx_tag,
    input logic [TAG_W-1:0] rx_tag_b
);
    bitcnt_t hi_run;
    bitcnt_t lo_run;
    logic    had_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run   <= '0;
            lo_run   <= '0;
            had_high <= 1'b0;
        end else if (sync_out) begin
            hi_run   <= hi_run + 1'b1;
            lo_run   <= '0;
            had_high <= 1'b1;
        end else begin
            hi_run <= '0;
            lo_run <= lo_run + 1'b1;
        end
    end

    // R1
    sync_high_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_out) |-> hi_run == bitcnt_t'(TAG_W));

    // R1
    sync_low_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sync_out) && had_high) |-> lo_run == bitcnt_t'(FRAME_W - TAG_W));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R4
    done_at_frame_start_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (sync_out && hi_run == '0));

    // R5
    ready_merge_chk: assert property (@(posedge clk) disable iff (rst)
        codec_ready == (rx_tag[READY_BIT] | rx_tag_b[READY_BIT]));

    // R6
    sec_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !$past(sec_en)) |-> rx_tag_b == '0);

    // R7
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sync_out && !sdata_out && !frame_done && !codec_ready));
endmodule

bind aclink_frame_ctrl aclink_frame_chk u_chk (
    .clk         (bit_clk),
    .rst         (rst),
    .sec_en      (sec_en),
    .sync_out    (sync_out),
    .sdata_out   (sdata_out),
    .frame_done  (frame_done),
    .codec_ready (codec_ready),
    .rx_tag      (rx_tag),
    .rx_tag_b    (rx_tag_b)
);

// File: tb/aclink_frame_ctrl_test.sv
module aclink_frame_ctrl_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sec_en = 1'b0;
    logic [15:0]  tx_tag = '0;
    logic [239:0] tx_slots = '0;
    logic         sdin_a = 1'b0;
    logic         sdin_b = 1'b0;
    logic         sdata_out, sync_out, frame_done, codec_ready;
    logic [15:0]  rx_tag, rx_tag_b;
    logic [239:0] rx_slots;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    aclink_frame_ctrl uut (
        .bit_clk(clk), .rst(rst), .sec_en(sec_en), .tx_tag(tx_tag),
        .tx_slots(tx_slots), .sdin_a(sdin_a), .sdin_b(sdin_b),
        .sdata_out(sdata_out), .sync_out(sync_out), .rx_tag(rx_tag),
        .rx_slots(rx_slots), .rx_tag_b(rx_tag_b), .frame_done(frame_done),
        .codec_ready(codec_ready)
    );

    typedef struct packed {
        logic [15:0] txt;
        logic [7:0]  seed;
        logic [15:0] at;
        logic [15:0] bt;
        logic        en;
        logic        rdy;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{16'hF800, 8'h11, 16'h8000, 16'h0000, 1'b0, 1'b1},
        '{16'h9C00, 8'h5A, 16'h0000, 16'h8000, 1'b1, 1'b1},
        '{16'h0000, 8'hA5, 16'h0000, 16'h8000, 1'b0, 1'b0},
        '{16'hFFFF, 8'hFF, 16'h7FFF, 16'h7FFF, 1'b1, 1'b0},
        '{16'h8001, 8'h00, 16'hC000, 16'hFFFF, 1'b1, 1'b1}
    };

    function automatic logic [239:0] mk_slots(input logic [7:0] s);
        logic [239:0] r = '0;
        for (int i = 0; i < 12; i++) begin
            logic [7:0] lo = s * 8'd3 + 8'(i);
            r[239 - 20*i -: 20] = {4'(i), s, lo};
        end
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_capture(input vec_t v);
        chk("R4", "frame_done at capture", 256'(frame_done), 256'(1));
        chk("R4", "rx_tag", 256'(rx_tag), 256'(v.at));
        chk("R4", "rx_slots", 256'(rx_slots), 256'(mk_slots(v.seed ^ 8'h3C)));
        chk("R6", "rx_tag_b", 256'(rx_tag_b), 256'(v.en ? v.bt : 16'h0));
        chk(v.en ? "R5" : "R6", "codec_ready", 256'(codec_ready), 256'(v.rdy));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [255:0] exp_tx, rxa, rxb;
        repeat (3) @(posedge clk);
        #2;
        // R7 reset state
        chk("R7", "sync in reset", 256'(sync_out), 256'(0));
        chk("R7", "sdata in reset", 256'(sdata_out), 256'(0));
        chk("R7", "done in reset", 256'(frame_done), 256'(0));
        chk("R7", "ready in reset", 256'(codec_ready), 256'(0));
        chk("R7", "rx_tag in reset", 256'(rx_tag), 256'(0));
        tx_tag   = VECS[0].txt;
        tx_slots = mk_slots(VECS[0].seed);
        rst = 1'b0;

        for (int f = 0; f < NV; f++) begin
            exp_tx = {VECS[f].txt, mk_slots(VECS[f].seed)};
            rxa    = {VECS[f].at, mk_slots(VECS[f].seed ^ 8'h3C)};
            rxb    = {VECS[f].bt, mk_slots(~VECS[f].seed)};
            for (int k = 0; k < 256; k++) begin
                @(posedge clk);
                #2;
                chk("R1", "sync_out", 256'(sync_out), 256'(k < 16));
                chk(k >= 8 ? "R3" : "R2", "sdata_out", 256'(sdata_out), 256'(exp_tx[255-k]));
                if (k == 0) begin
                    if (f > 0) chk_capture(VECS[f-1]);
                    else chk("R7", "no done before full frame", 256'(frame_done), 256'(0));
                end
                if (k == 1) begin
                    chk("R4", "done one cycle", 256'(frame_done), 256'(0));
                    sec_en = VECS[f].en;
                end
                if (k == 8) begin
                    tx_tag   = ~tx_tag;
                    tx_slots = ~tx_slots;
                end
                sdin_a = rxa[255-k];
                sdin_b = rxb[255-k];
                if (k == 255 && f < NV - 1) begin
                    tx_tag   = VECS[f+1].txt;
                    tx_slots = mk_slots(VECS[f+1].seed);
                end
            end
        end
        @(posedge clk);
        #2;
        chk_capture(VECS[NV-1]);

        // R7 mid-frame reset and restart
        sdin_a = 1'b0;
        sdin_b = 1'b0;
        repeat (20) @(posedge clk);
        #2;
        rst      = 1'b1;
        tx_tag   = 16'hA5C3;
        tx_slots = mk_slots(8'h77);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #2;
            chk("R7", "sync held low", 256'(sync_out), 256'(0));
            chk("R7", "sdata held low", 256'(sdata_out), 256'(0));
            chk("R7", "done low in reset", 256'(frame_done), 256'(0));
        end
        chk("R7", "rx_tag cleared", 256'(rx_tag), 256'(0));
        chk("R7", "ready cleared", 256'(codec_ready), 256'(0));
        rst = 1'b0;
        exp_tx = {16'hA5C3, mk_slots(8'h77)};
        for (int k = 0; k < 256; k++) begin
            @(posedge clk);
            #2;
            if (k == 0) begin
                chk("R7", "restart sync", 256'(sync_out), 256'(1));
                chk("R7", "restart first bit", 256'(sdata_out), 256'(1));
                chk("R7", "no done at restart", 256'(frame_done), 256'(0));
            end else begin
                chk("R1", "sync after restart", 256'(sync_out), 256'(k < 16));
                chk("R2", "sdata after restart", 256'(sdata_out), 256'(exp_tx[255-k]));
            end
        end
        @(posedge clk);
        #2;
        chk("R4", "done after first full frame", 256'(frame_done), 256'(1));
        chk("R5", "ready with zero input", 256'(codec_ready), 256'(0));
        finish_run();
    end
endmodule